// File: doc/BRIEF.md
# GPIO Bank with Interrupt Detection

A bank of up to 32 general-purpose pins behind a small word-wide register port. Each pin has an output value and an output enable. Its input level is brought in through a two-stage synchroniser and can be read back whatever the pin's direction. Each pin can be set to detect either an edge or a level. A single polarity bit per pin picks a rising edge or high level, or a falling edge or low level. A detected event sets a sticky pending bit, and that bit stays set until software writes a one to it through the clear register.

Pending bits set whatever the interrupt enable holds. The single interrupt output is a registered OR, across all pins, of pending AND enable. The hardware has no dual-edge mode. Software that needs both edges flips a pin's polarity after each event. A change of polarity or type alone must therefore never produce an edge event.

The register port is a single write strobe, a 3-bit word address, write data and combinational read data. The word map is:

| Address | Register | Access |
|---|---|---|
| 0 | output value | read/write |
| 1 | output enable | read/write |
| 2 | input level | read only |
| 3 | detect type (1 edge, 0 level) | read/write |
| 4 | polarity (1 rising/high, 0 falling/low) | read/write |
| 5 | interrupt enable | read/write |
| 6 | clear (write one to clear) | write, reads 0 |
| 7 | pending | read only |

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset, output value, output enable, interrupt enable and pending read 0, and the interrupt output is 0. Detect type and polarity read all ones over the pin width, which means rising-edge detection.
- R2: A write to address 0 sets pinOut, and a write to address 1 sets pinOe, both from the clock edge of the write. Each register reads back what was written.
- R3: Address 2 returns the pin levels as they were two clock edges earlier, for every pin, whether that pin is an input or an output.
- R4: A pin with type 1 sets its pending bit (address 7) on a rising edge when polarity is 1, or on a falling edge when polarity is 0. The bit sets on the third clock edge after the pin changes.
- R5: A pin with type 0 sets its pending bit while its synchronised level equals its polarity bit. The bit stays set after the level goes away.
- R6: Writing a one to a bit at address 6 clears that pending bit, and writing a zero leaves it unchanged. Address 6 reads 0.
- R7: If a detected event and a clear of the same bit fall in the same cycle, the bit stays set.
- R8: Writing the polarity or type register while a pin's input is stable never, by itself, produces an edge event.
- R9: Pending bits set whatever the interrupt enable holds. irqOut equals the OR over all pins of pending AND enable, one clock edge late.
- R10: Read-data bits at and above PIN_COUNT read as 0, and written data in those bits is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rstN | input | 1 | asynchronous reset, active low |
| busWe | input | 1 | write strobe for the addressed register |
| busAddr | input | 3 | word address |
| busWdata | input | 32 | write data |
| busRdata | output | 32 | read data for busAddr, combinational |
| pinIn | input | PIN_COUNT | pin input levels, asynchronous |
| pinOut | output | PIN_COUNT | pin output values |
| pinOe | output | PIN_COUNT | pin output enables, 1 drives the pin |
| irqOut | output | 1 | aggregated interrupt, registered |

## Verification
The bench goes after sticky level detection. A design that tracks the live level would drop the pending bit as soon as the pin returns. It also checks a clear written while the level is still active: a design that lets the clear win would lose the event. Polarity is rewritten on a pin that is high and stable, which catches a design that compares polarity rather than the sampled value and so raises a false edge. Finally, the bench shows pending bits set with the enable at zero and irqOut lagging the enable write by one cycle, which exposes a design that gates status with the enable or drives the interrupt combinationally.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_OUT  = 3'd0,
    A_OE   = 3'd1,
    A_IN   = 3'd2,
    A_TYPE = 3'd3,
    A_POL  = 3'd4,
    A_EN   = 3'd5,
    A_CLR  = 3'd6,
    A_STAT = 3'd7
  } regAddr_e;

  typedef struct packed {
    logic             wrOut;
    logic             wrOe;
    logic             wrType;
    logic             wrPol;
    logic             wrEn;
    logic             wrClr;
    logic [ADDR_W-1:0] rdSel;
  } ctlStrobes_t;
endpackage

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
(
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  output ctlStrobes_t       strobes
);
  always_comb begin
    strobes       = '0;
    strobes.rdSel = busAddr;
    if (busWe) begin
      case (regAddr_e'(busAddr))
        A_OUT:   strobes.wrOut  = 1'b1;
        A_OE:    strobes.wrOe   = 1'b1;
        A_TYPE:  strobes.wrType = 1'b1;
        A_POL:   strobes.wrPol  = 1'b1;
        A_EN:    strobes.wrEn   = 1'b1;
        A_CLR:   strobes.wrClr  = 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/gpio_bank_dp.sv
module gpio_bank_dp
  import gpio_bank_pkg::*;
#(
  parameter int PIN_COUNT = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctlStrobes_t          strobes,
  input  logic [DATA_W-1:0]    busWdata,
  output logic [DATA_W-1:0]    busRdata,
  input  logic [PIN_COUNT-1:0] pinIn,
  output logic [PIN_COUNT-1:0] pinOut,
  output logic [PIN_COUNT-1:0] pinOe,
  output logic                 irqOut
);
  logic [PIN_COUNT-1:0] outQ, oeQ, typeQ, polQ, enQ, statQ;
  logic [PIN_COUNT-1:0] syncA, syncB, prevQ, hitVec, clrMask, wdat;
  logic                 irqQ;

  assign wdat    = busWdata[PIN_COUNT-1:0];
  assign clrMask = strobes.wrClr ? wdat : '0;

  // per-pin event detection from sampled values only
  for (genvar i = 0; i < PIN_COUNT; i++) begin : g_det
    logic rise, fall;
    assign rise      = syncB[i] & ~prevQ[i];
    assign fall      = ~syncB[i] & prevQ[i];
    assign hitVec[i] = typeQ[i] ? (polQ[i] ? rise : fall)
                                : (syncB[i] == polQ[i]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outQ  <= '0;
      oeQ   <= '0;
      typeQ <= '1;
      polQ  <= '1;
      enQ   <= '0;
      statQ <= '0;
      syncA <= '0;
      syncB <= '0;
      prevQ <= '0;
      irqQ  <= 1'b0;
    end else begin
      if (strobes.wrOut)  outQ  <= wdat;
      if (strobes.wrOe)   oeQ   <= wdat;
      if (strobes.wrType) typeQ <= wdat;
      if (strobes.wrPol)  polQ  <= wdat;
      if (strobes.wrEn)   enQ   <= wdat;
      syncA <= pinIn;
      syncB <= syncA;
      prevQ <= syncB;
      statQ <= (statQ & ~clrMask) | hitVec;
      irqQ  <= |(statQ & enQ);
    end
  end

  always_comb begin
    busRdata = '0;
    case (regAddr_e'(strobes.rdSel))
      A_OUT:   busRdata[PIN_COUNT-1:0] = outQ;
      A_OE:    busRdata[PIN_COUNT-1:0] = oeQ;
      A_IN:    busRdata[PIN_COUNT-1:0] = syncB;
      A_TYPE:  busRdata[PIN_COUNT-1:0] = typeQ;
      A_POL:   busRdata[PIN_COUNT-1:0] = polQ;
      A_EN:    busRdata[PIN_COUNT-1:0] = enQ;
      A_STAT:  busRdata[PIN_COUNT-1:0] = statQ;
      default: busRdata = '0;
    endcase
  end

  assign pinOut = outQ;
  assign pinOe  = oeQ;
  assign irqOut = irqQ;
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_bank_pkg::*;
#(
  parameter int PIN_COUNT = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busWe,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic [DATA_W-1:0]    busWdata,
  output logic [DATA_W-1:0]    busRdata,
  input  logic [PIN_COUNT-1:0] pinIn,
  output logic [PIN_COUNT-1:0] pinOut,
  output logic [PIN_COUNT-1:0] pinOe,
  output logic                 irqOut
);
  ctlStrobes_t strobes;

  gpio_bank_ctrl u_ctrl (
    .busWe   (busWe),
    .busAddr (busAddr),
    .strobes (strobes)
  );

  gpio_bank_dp #(.PIN_COUNT(PIN_COUNT)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .pinIn    (pinIn),
    .pinOut   (pinOut),
    .pinOe    (pinOe),
    .irqOut   (irqOut)
  );
endmodule

// File: rtl/gpio_bank_checker.sv
module gpio_bank_checker
  import gpio_bank_pkg::*;
#(
  parameter int PIN_COUNT = 16
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 busWe,
  input logic [ADDR_W-1:0]    busAddr,
  input logic [DATA_W-1:0]    busWdata,
  input logic [DATA_W-1:0]    busRdata,
  input logic [PIN_COUNT-1:0] pinIn,
  input logic [PIN_COUNT-1:0] pinOut,
  input logic [PIN_COUNT-1:0] pinOe,
  input logic                 irqOut
);
  localparam logic [DATA_W-1:0] PIN_MASK =
    (PIN_COUNT >= DATA_W) ? '1 : ((DATA_W'(1) << PIN_COUNT) - 1);

  logic [1:0] sinceRst;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sinceRst <= '0;
    else if (sinceRst != 2'd3) sinceRst <= sinceRst + 2'd1;
  end

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rstN |-> (pinOe == '0 && pinOut == '0 && !irqOut));

  p_out_follow_r2: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == A_OUT) |=> (pinOut == $past(busWdata[PIN_COUNT-1:0])));

  p_oe_follow_r2: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == A_OE) |=> (pinOe == $past(busWdata[PIN_COUNT-1:0])));

  p_input_sync_r3: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst == 2'd3 && busAddr == A_IN) |-> (busRdata[PIN_COUNT-1:0] == $past(pinIn, 2)));

  p_clear_reads_zero_r6: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == A_CLR) |-> (busRdata == '0));

  p_high_bits_zero_r10: assert property (@(posedge clk) disable iff (!rstN)
    ((busRdata & ~PIN_MASK) == '0));
endmodule

bind gpio_irq_bank gpio_bank_checker #(.PIN_COUNT(PIN_COUNT)) u_chk (.*);

// File: tb/tb_gpio_irq_bank.sv
`timescale 1ns/1ps
module tb_gpio_irq_bank;
  localparam int P = 16;
  localparam real HALF = 2.5;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          busWe = 1'b0;
  logic [2:0]    busAddr = 3'd0;
  logic [31:0]   busWdata = '0;
  logic [31:0]   busRdata;
  logic [P-1:0]  pinIn = '0;
  logic [P-1:0]  pinOut, pinOe;
  logic          irqOut;

  int checks = 0;
  int errors = 0;

  always #(HALF) clk = ~clk;

  gpio_irq_bank #(.PIN_COUNT(P)) dut (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .pinIn(pinIn),
    .pinOut(pinOut), .pinOe(pinOe), .irqOut(irqOut)
  );

  // behavioural reference model
  int unsigned mOut, mOe, mType, mPol, mEn, mStat, mS1, mS2, mPrev;
  bit mIrq;
  int unsigned pmask = (1 << P) - 1;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mOut = 0; mOe = 0; mType = pmask; mPol = pmask; mEn = 0;
      mStat = 0; mS1 = 0; mS2 = 0; mPrev = 0; mIrq = 0;
    end else begin
      int unsigned ev, clr, wd;
      ev = 0;
      for (int i = 0; i < P; i++) begin
        bit cur, old, pl;
        cur = mS2[i]; old = mPrev[i]; pl = mPol[i];
        if (mType[i]) begin
          if (pl && cur && !old) ev |= (1 << i);
          if (!pl && !cur && old) ev |= (1 << i);
        end else if (cur == pl) ev |= (1 << i);
      end
      wd  = busWdata & pmask;
      clr = (busWe && busAddr == 3'd6) ? wd : 0;
      mIrq  = ((mStat & mEn) != 0);
      mStat = (mStat & ~clr) | ev;
      mPrev = mS2; mS2 = mS1; mS1 = pinIn;
      if (busWe) begin
        case (busAddr)
          3'd0: mOut = wd;
          3'd1: mOe = wd;
          3'd3: mType = wd;
          3'd4: mPol = wd;
          3'd5: mEn = wd;
          default: ;
        endcase
      end
    end
  end

  function automatic int unsigned modelRead(logic [2:0] a);
    case (a)
      3'd0: return mOut;
      3'd1: return mOe;
      3'd2: return mS2;
      3'd3: return mType;
      3'd4: return mPol;
      3'd5: return mEn;
      3'd7: return mStat;
      default: return 0;
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rstN) begin
      check("R2 model pinOut", 32'(pinOut), mOut);
      check("R2 model pinOe", 32'(pinOe), mOe);
      check("R9 model irqOut", 32'(irqOut), 32'(mIrq));
      check("R4 R5 R3 model read", busRdata, modelRead(busAddr));
    end
  end

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); #1;
    busWe = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk); #1;
    busWe = 1'b0; busWdata = '0;
  endtask

  task automatic rd(logic [2:0] a, logic [31:0] exp, string tag);
    @(negedge clk); #1;
    busAddr = a;
    #1;
    check(tag, busRdata, exp);
  endtask

  task automatic setPins(logic [P-1:0] v);
    @(negedge clk); #1;
    pinIn = v;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(HALF * 2 * 100000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    // R1 reset state
    rd(3'd3, 32'h0000_FFFF, "R1 type reset");
    rd(3'd4, 32'h0000_FFFF, "R1 pol reset");
    rd(3'd5, 32'h0, "R1 enable reset");
    rd(3'd7, 32'h0, "R1 pending reset");
    check("R1 pinOe reset", 32'(pinOe), 32'h0);
    check("R1 irq reset", 32'(irqOut), 32'h0);
    // R2 outputs, R10 upper bits
    wr(3'd0, 32'h0000_A5A5);
    wr(3'd1, 32'h0000_00FF);
    check("R2 pinOut", 32'(pinOut), 32'h0000_A5A5);
    check("R2 pinOe", 32'(pinOe), 32'h0000_00FF);
    rd(3'd1, 32'h0000_00FF, "R2 oe readback");
    wr(3'd0, 32'hFFFF_FFFF);
    rd(3'd0, 32'h0000_FFFF, "R10 upper bits ignored");
    // R3 input read regardless of direction, R4 rising edges
    setPins(16'h1234);
    rd(3'd2, 32'h0000_1234, "R3 input level");
    rd(3'd7, 32'h0000_1234, "R4 rising edge pending");
    wr(3'd6, 32'hFFFF_FFFF);
    rd(3'd7, 32'h0, "R6 clear all");
    rd(3'd6, 32'h0, "R6 clear reads zero");
    // R8 polarity change on a stable high pin
    wr(3'd4, 32'h0000_FFFB);
    repeat (3) @(negedge clk);
    rd(3'd7, 32'h0, "R8 no spurious edge");
    // R4 falling edge on bit2
    setPins(16'h1230);
    rd(3'd7, 32'h0000_0004, "R4 falling edge pending");
    wr(3'd6, 32'h0);
    rd(3'd7, 32'h0000_0004, "R6 zero write no effect");
    wr(3'd6, 32'h0000_0004);
    rd(3'd7, 32'h0, "R6 clear one bit");
    // R5 level high on bit8, sticky
    wr(3'd3, 32'h0000_FEFF);
    repeat (3) @(negedge clk);
    rd(3'd7, 32'h0, "R5 level not matched");
    setPins(16'h1330);
    rd(3'd7, 32'h0000_0100, "R5 level pending");
    check("R9 no irq while disabled", 32'(irqOut), 32'h0);
    setPins(16'h1230);
    rd(3'd7, 32'h0000_0100, "R5 level sticky");
    wr(3'd6, 32'h0000_0100);
    rd(3'd7, 32'h0, "R5 cleared after level gone");
    // R7 event wins over clear while level held
    setPins(16'h1330);
    wr(3'd6, 32'h0000_0100);
    rd(3'd7, 32'h0000_0100, "R7 event beats clear");
    setPins(16'h1230);
    wr(3'd6, 32'h0000_0100);
    rd(3'd7, 32'h0, "R7 clear after release");
    // R9 interrupt aggregation with one-cycle lag
    setPins(16'h1330);
    setPins(16'h1230);
    @(negedge clk); #1;
    busWe = 1'b1; busAddr = 3'd5; busWdata = 32'h0000_0100;
    @(negedge clk);
    check("R9 irq lags enable", 32'(irqOut), 32'h0);
    #1; busWe = 1'b0; busWdata = '0;
    @(negedge clk);
    check("R9 irq asserted", 32'(irqOut), 32'h1);
    wr(3'd6, 32'h0000_0100);
    repeat (2) @(negedge clk);
    check("R9 irq drops after clear", 32'(irqOut), 32'h0);
    repeat (4) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule